// File: doc/BRIEF.md
# Instruction Byte Aligner

This block sits between instruction fetch and the decoder. It keeps a 32-byte decode window in which the oldest undecoded byte is always at position 0. Every clock the decoder states how many bytes it used. The aligner drops those bytes, slides the rest down to position 0, and in the same clock places the next fetch packet directly behind the bytes that remain. A packet is either 16 bytes wide, when it comes from the cache, or 8 bytes wide, when it comes from the bus.

When the next packet does not fit behind the remaining bytes, it is parked in one of three 16-byte holding slots. The slots drain in arrival order as soon as the window has room for them. A redirect packet restarts the stream. It throws away everything that is stored and loads the window so that the branch-target byte, selected by a start offset inside the packet, lands at position 0.

Top module: `instr_align_buf`

## Requirements
- R1: After reset, `winCount` is 0, every byte of `winData` is 0 and `fetchReady` is 1.
- R2: A redirect packet (`fetchValid` and `fetchRedirect` both high) sets, at the next edge, window byte 0 to packet byte `fetchOffset` and the following window bytes to the packet bytes after it. `winCount` becomes the packet length minus the offset, or 0 if the offset is not below the length.
- R3: A redirect discards all window bytes and all holding-slot contents at the same edge at which it loads the target packet. Afterwards `fetchReady` is 1.
- R4: At each edge the window drops its first min(`consumeCnt`, `winCount`) bytes and shifts the remaining bytes down to position 0. A consume count larger than `winCount` empties the window.
- R5: When all holding slots are empty and the remaining bytes plus the packet length do not exceed 32, an accepted packet is appended in the same edge, starting at window position (remaining count).
- R6: A packet that is accepted but not appended directly goes into a holding slot. The oldest slot is appended behind the remaining bytes as soon as it fits. Slots empty in arrival order, and a waiting slot always goes before a newly arriving packet.
- R7: With `fetchNarrow` = 1 the packet length is 8 and only `fetchData` bytes 0..7 (bits 63:0) are used. Upper bytes never reach the window. With `fetchNarrow` = 0 the length is 16.
- R8: `fetchReady` is 0 exactly when all three holding slots are occupied. A non-redirect packet offered while `fetchReady` is 0 is not taken and leaves the window and the slots unchanged apart from the consume.
- R9: Window bytes at positions at or above `winCount` read 0. Byte k of `winData` is bits 8k+7:8k.
- R10: A redirect packet is taken even when `fetchReady` is 0. `fetchOffset` has no effect on non-redirect packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchValid | input | 1 | A fetch packet is offered |
| fetchReady | output | 1 | A non-redirect packet can be taken |
| fetchRedirect | input | 1 | Packet is the first one after a branch redirect |
| fetchNarrow | input | 1 | 1: 8-byte packet, 0: 16-byte packet |
| fetchOffset | input | 4 | Target byte offset within a redirect packet |
| fetchData | input | 128 | Packet bytes, byte k at bits 8k+7:8k |
| consumeCnt | input | 6 | Bytes used by the decoder this clock |
| winData | output | 256 | Left-aligned decode window |
| winCount | output | 6 | Number of valid window bytes, 0 to 32 |

## Verification
`winData` and `winCount` come from registers. Their response to the inputs of one cycle, including the consume count, a direct append, a slot drain and a redirect load, is due right after the next rising edge. `fetchReady` depends only on slot occupancy, so it is valid within the cycle in which the inputs are driven. The bench drives its inputs just after an edge and checks `fetchReady` 1 ns later. It then checks the window and the count 2 ns after the following edge, against a byte-level model that it updates once per cycle.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int WIN_BYTES    = 32;
  localparam int PKT_BYTES    = 16;
  localparam int NARROW_BYTES = 8;
  localparam int NUM_HOLD     = 3;

  localparam int CNT_W  = $clog2(WIN_BYTES + 1);
  localparam int LEN_W  = $clog2(PKT_BYTES + 1);
  localparam int OFS_W  = $clog2(PKT_BYTES);
  localparam int PTR_W  = $clog2(NUM_HOLD);
  localparam int HCNT_W = $clog2(NUM_HOLD + 1);

  typedef struct packed {
    logic             loadTarget;
    logic             fillEn;
    logic             fillFromHold;
    logic             pushEn;
    logic [CNT_W-1:0] shiftAmt;
    logic [CNT_W-1:0] fillPos;
    logic [OFS_W-1:0] targetOfs;
    logic [PTR_W-1:0] rdPtr;
    logic [PTR_W-1:0] wrPtr;
  } bufStrobes_t;
endpackage

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl
  import ibuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic             fetchRedirect,
  input  logic             fetchNarrow,
  input  logic [OFS_W-1:0] fetchOffset,
  input  logic [CNT_W-1:0] consumeCnt,
  output logic             fetchReady,
  output logic [CNT_W-1:0] winCount,
  output bufStrobes_t      strb
);
  logic [CNT_W-1:0]  winCountQ, countNext, cons, rem;
  logic [LEN_W-1:0]  holdLen [NUM_HOLD];
  logic [HCNT_W-1:0] holdCnt;
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [LEN_W-1:0]  inLen, headLen, tgtLen;
  logic              redirAcc, accept, headFits, inDirect, pushEn;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_HOLD - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign fetchReady = (holdCnt < HCNT_W'(NUM_HOLD));
  assign winCount   = winCountQ;

  always_comb begin
    inLen    = fetchNarrow ? LEN_W'(NARROW_BYTES) : LEN_W'(PKT_BYTES);
    cons     = (consumeCnt > winCountQ) ? winCountQ : consumeCnt;
    rem      = winCountQ - cons;
    headLen  = holdLen[rdPtr];
    redirAcc = fetchValid && fetchRedirect;
    headFits = (holdCnt != '0) &&
               ((CNT_W+1)'(rem) + (CNT_W+1)'(headLen) <= (CNT_W+1)'(WIN_BYTES));
    accept   = fetchValid && !fetchRedirect && fetchReady;
    inDirect = accept && (holdCnt == '0) &&
               ((CNT_W+1)'(rem) + (CNT_W+1)'(inLen) <= (CNT_W+1)'(WIN_BYTES));
    pushEn   = accept && !inDirect;
    tgtLen   = (inLen > LEN_W'(fetchOffset)) ? inLen - LEN_W'(fetchOffset) : '0;
    if (redirAcc)
      countNext = CNT_W'(tgtLen);
    else
      countNext = rem + (headFits ? CNT_W'(headLen) : '0) + (inDirect ? CNT_W'(inLen) : '0);

    strb.loadTarget   = redirAcc;
    strb.fillEn       = !redirAcc && (headFits || inDirect);
    strb.fillFromHold = headFits;
    strb.pushEn       = !redirAcc && pushEn;
    strb.shiftAmt     = cons;
    strb.fillPos      = rem;
    strb.targetOfs    = fetchOffset;
    strb.rdPtr        = rdPtr;
    strb.wrPtr        = wrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCountQ <= '0;
      holdCnt   <= '0;
      rdPtr     <= '0;
      wrPtr     <= '0;
      for (int i = 0; i < NUM_HOLD; i++) holdLen[i] <= '0;
    end else if (redirAcc) begin
      winCountQ <= countNext;
      holdCnt   <= '0;
      rdPtr     <= '0;
      wrPtr     <= '0;
    end else begin
      winCountQ <= countNext;
      if (pushEn) begin
        holdLen[wrPtr] <= inLen;
        wrPtr          <= nextPtr(wrPtr);
      end
      if (headFits) rdPtr <= nextPtr(rdPtr);
      holdCnt <= holdCnt + HCNT_W'(pushEn) - HCNT_W'(headFits);
    end
  end

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    winCountQ <= CNT_W'(WIN_BYTES));

  assert_no_grow_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchRedirect && holdCnt == HCNT_W'(NUM_HOLD)) |=> holdCnt <= $past(holdCnt));

  assert_redir_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    redirAcc |=> (holdCnt == '0) && fetchReady);

  assert_drain_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && holdCnt == '0) |=>
      winCountQ == $past(winCountQ) -
        (($past(consumeCnt) > $past(winCountQ)) ? $past(winCountQ) : $past(consumeCnt)));

  assert_redir_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (redirAcc && !fetchNarrow && fetchOffset == '0) |=> winCountQ == CNT_W'(PKT_BYTES));
endmodule

// File: rtl/ibuf_datapath.sv
module ibuf_datapath
  import ibuf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  bufStrobes_t            strb,
  input  logic                   fetchNarrow,
  input  logic [PKT_BYTES*8-1:0] fetchData,
  output logic [WIN_BYTES*8-1:0] winData
);
  localparam int PKT_W = PKT_BYTES * 8;
  localparam int WIN_W = WIN_BYTES * 8;

  logic [PKT_W-1:0] pktMasked, fillPkt;
  logic [PKT_W-1:0] holdData [NUM_HOLD];
  logic [WIN_W-1:0] winQ, kept, fillWide, targetWide;

  for (genvar b = 0; b < PKT_BYTES; b++) begin : g_mask
    if (b < NARROW_BYTES) begin : g_low
      assign pktMasked[b*8 +: 8] = fetchData[b*8 +: 8];
    end else begin : g_high
      assign pktMasked[b*8 +: 8] = fetchNarrow ? 8'h00 : fetchData[b*8 +: 8];
    end
  end

  always_comb begin
    fillPkt    = strb.fillFromHold ? holdData[strb.rdPtr] : pktMasked;
    kept       = winQ >> {strb.shiftAmt, 3'b000};
    fillWide   = WIN_W'(fillPkt) << {strb.fillPos, 3'b000};
    targetWide = WIN_W'(pktMasked) >> {strb.targetOfs, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      winQ <= '0;
    else if (strb.loadTarget)
      winQ <= targetWide;
    else
      winQ <= kept | (strb.fillEn ? fillWide : '0);
  end

  always_ff @(posedge clk) begin
    if (strb.pushEn) holdData[strb.wrPtr] <= pktMasked;
  end

  assign winData = winQ;

  assert_shift_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTarget && !strb.fillEn) |=>
      winData == ($past(winData) >> {$past(strb.shiftAmt), 3'b000}));

  assert_target_ofs0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTarget && strb.targetOfs == '0) |=>
      winData[7:0] == $past(pktMasked[7:0]));
endmodule

// File: rtl/instr_align_buf.sv
module instr_align_buf
  import ibuf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fetchValid,
  output logic                   fetchReady,
  input  logic                   fetchRedirect,
  input  logic                   fetchNarrow,
  input  logic [OFS_W-1:0]       fetchOffset,
  input  logic [PKT_BYTES*8-1:0] fetchData,
  input  logic [CNT_W-1:0]       consumeCnt,
  output logic [WIN_BYTES*8-1:0] winData,
  output logic [CNT_W-1:0]       winCount
);
  bufStrobes_t strb;

  ibuf_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchRedirect(fetchRedirect),
    .fetchNarrow(fetchNarrow), .fetchOffset(fetchOffset),
    .consumeCnt(consumeCnt), .fetchReady(fetchReady),
    .winCount(winCount), .strb(strb)
  );

  ibuf_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fetchNarrow(fetchNarrow), .fetchData(fetchData),
    .winData(winData)
  );
endmodule

// File: tb/sim_instr_align_buf.sv
module sim_instr_align_buf;
  import ibuf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic                   fetchValid = 1'b0, fetchRedirect = 1'b0, fetchNarrow = 1'b0;
  logic                   fetchReady;
  logic [OFS_W-1:0]       fetchOffset = '0;
  logic [PKT_BYTES*8-1:0] fetchData = '0;
  logic [CNT_W-1:0]       consumeCnt = '0;
  logic [WIN_BYTES*8-1:0] winData;
  logic [CNT_W-1:0]       winCount;

  instr_align_buf u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchRedirect(fetchRedirect), .fetchNarrow(fetchNarrow), .fetchOffset(fetchOffset),
    .fetchData(fetchData), .consumeCnt(consumeCnt), .winData(winData), .winCount(winCount)
  );

  int total = 0;
  int bad = 0;
  int seq = 0;
  logic [7:0] mWin [WIN_BYTES];
  int mCnt = 0;
  logic [7:0] mHold [NUM_HOLD][PKT_BYTES];
  int mHLen [NUM_HOLD];
  int mHN = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [WIN_BYTES*8-1:0] act, input logic [WIN_BYTES*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [WIN_BYTES*8-1:0] modelVec();
    logic [WIN_BYTES*8-1:0] v = '0;
    for (int i = 0; i < mCnt; i++) v[i*8 +: 8] = mWin[i];
    return v;
  endfunction

  task automatic checkWin(input string tag);
    chk(winCount == CNT_W'(mCnt), {tag, " count"}, WIN_BYTES*8'(winCount), WIN_BYTES*8'(mCnt));
    chk(winData == modelVec(), {tag, " window bytes, zero tail R9"}, winData, modelVec());
  endtask

  task automatic step(input bit v, input bit r, input bit n, input int ofs,
                      input int cons, input string tag);
    logic [PKT_BYTES*8-1:0] pkt;
    int len, c, rem;
    bit rdy, acc, fitH, dir;
    len = n ? NARROW_BYTES : PKT_BYTES;
    for (int b = 0; b < PKT_BYTES; b++)
      pkt[b*8 +: 8] = (n && b >= NARROW_BYTES) ? 8'hEE : 8'(seq + b);
    if (v) seq += 16;
    fetchValid = v; fetchRedirect = r; fetchNarrow = n;
    fetchOffset = OFS_W'(ofs); fetchData = pkt; consumeCnt = CNT_W'(cons);
    #1;
    rdy = (mHN < NUM_HOLD);
    chk(fetchReady == rdy, {tag, " ready R8"}, WIN_BYTES*8'(fetchReady), WIN_BYTES*8'(rdy));
    c = (cons > mCnt) ? mCnt : cons;
    rem = mCnt - c;
    if (v && r) begin
      mCnt = 0;
      for (int b = ofs; b < len; b++) begin
        mWin[mCnt] = pkt[b*8 +: 8];
        mCnt++;
      end
      mHN = 0;
    end else begin
      for (int i = 0; i < rem; i++) mWin[i] = mWin[i + c];
      mCnt = rem;
      acc  = v && rdy;
      fitH = (mHN > 0) && (rem + mHLen[0] <= WIN_BYTES);
      dir  = acc && (mHN == 0) && (rem + len <= WIN_BYTES);
      if (fitH) begin
        for (int b = 0; b < mHLen[0]; b++) begin
          mWin[mCnt] = mHold[0][b];
          mCnt++;
        end
        for (int i = 0; i < NUM_HOLD - 1; i++) begin
          mHLen[i] = mHLen[i + 1];
          for (int b = 0; b < PKT_BYTES; b++) mHold[i][b] = mHold[i + 1][b];
        end
        mHN--;
      end
      if (acc && !dir) begin
        for (int b = 0; b < PKT_BYTES; b++) mHold[mHN][b] = pkt[b*8 +: 8];
        mHLen[mHN] = len;
        mHN++;
      end
      if (dir) begin
        for (int b = 0; b < len; b++) begin
          mWin[mCnt] = pkt[b*8 +: 8];
          mCnt++;
        end
      end
    end
    @(posedge clk);
    #2;
    checkWin(tag);
  endtask

  initial begin
    repeat (8000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    checkWin("R1");
    chk(fetchReady == 1'b1, "R1 ready", WIN_BYTES*8'(fetchReady), 1);
    rstN = 1'b1;

    // R2 / R7: every offset in both packet widths, then a consume (R4)
    for (int n = 0; n < 2; n++) begin
      for (int ofs = 0; ofs < PKT_BYTES; ofs++) begin
        step(1, 1, n[0], ofs, 0, (n != 0) ? "R2 R7 narrow target" : "R2 target");
        step(0, 0, 0, 0, (ofs % 4) + 1, "R4 consume");
      end
    end

    // R5 / R6 / R8: fill window, then the three slots, then overflow
    step(1, 1, 0, 5, 0, "R2 target");
    step(1, 0, 0, 0, 0, "R5 direct append");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, "R6 park in slot");
    step(1, 0, 0, 0, 0, "R8 reject when full");
    step(1, 0, 1, 0, 2, "R8 reject when full");
    // R10 / R3: redirect while not ready
    step(1, 1, 0, 3, 0, "R10 redirect while full");
    step(0, 0, 0, 0, 0, "R3 slots discarded");

    // R4: consume larger than count clamps
    step(0, 0, 0, 0, 40, "R4 clamp");

    // mixed traffic: R5, R6, R7, R10 offset ignored
    for (int k = 0; k < 80; k++) begin
      step((k % 3) != 2, 0, k[0], k % 16, (k * 7) % 11,
           (k % 5 == 0) ? "R10 offset ignored" : (k[0] ? "R7 narrow stream" : "R6 stream"));
    end
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 5, "R6 drain order");
    step(1, 0, 0, 9, 0, "R5 append after drain");
    step(0, 0, 0, 0, 33, "R4 clamp");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule